// File: doc/BRIEF.md
# Branch Target Cache with Prediction

This block sits beside the fetch stage. Each cycle it takes the fetch program counter and answers straight away, with no register in the path: whether a branch or return at that address is known, whether it is predicted taken, and where it goes. When the prediction is taken, fetch can jump to the stored target in the same cycle, so a correctly predicted branch costs nothing. The cache is direct-mapped. Each entry holds a valid bit, an address tag, the branch target, a 2-bit saturating counter, a flag for unconditional or return branches, and one parity bit.

When a branch resolves in execute, the pipeline sends an update. The update carries the actual outcome and target, and also the prediction that fetch used for that branch. The block writes the entry, which allocates it on first use and trains or corrects it after that. It compares the actual result with the prediction that was used. On a mismatch it drives a redirect for two cycles with the correct program counter.

A clear command, issued on a memory barrier or a synchronizing branch, invalidates every entry. The clear walks the array one entry per cycle. Reset starts the same walk.

Top module: `branch_target_cache`

## Requirements
- R1: After reset is released, `busy_o` stays high for exactly ENTRIES rising edges. After that, every lookup misses.
- R2: After an update at address A is accepted, a lookup at A reports hit, and `lk_target_o` equals the update's target. A later update at A overwrites the stored target.
- R3: An entry last written with `up_kind_i` 1 (unconditional) or 2 (return) is predicted taken whatever its counter holds. Such an update leaves the counter of an existing entry unchanged.
- R4: Kind 0 (conditional) branches use a 2-bit counter. A newly allocated entry starts at 2 (weakly taken). A conditional update that hits the entry moves the counter up by one when taken, down by one when not taken, and the counter saturates at 0 and 3. The prediction is taken when the counter is 2 or 3.
- R5: An update mispredicts in three cases: it was predicted not taken and is taken; it was predicted taken and is not taken; or it was predicted taken, is taken, and has a different target. A mispredict raises `redirect_o` for exactly the two cycles after the update's clock edge. During those cycles `redirect_pc_o` is the target when the branch was taken and the branch address plus 4 otherwise. A correct prediction raises no redirect.
- R6: A return whose stored target is wrong is corrected in place. The next lookup returns the new target, still predicted taken.
- R7: A clear request raises `busy_o` from the next edge for ENTRIES edges. Lookups miss while it is high, and every entry is invalid afterwards. This includes an entry written by an update in the cycle just before the request.
- R8: An update presented while `busy_o` is high writes nothing. The redirect logic still evaluates it.
- R9: When parity is enabled, an entry whose stored parity bit differs from the even parity of its tag, target, counter and kind flag produces a miss.
- R10: The index is pc[IDX_W+1:2]. The tag is the remaining upper bits together with pc[1:0]. A lookup at an address that has the same index but a different upper part misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts an invalidating walk |
| lk_pc_i | input | PC_W | Fetch program counter to look up |
| lk_hit_o | output | 1 | Valid entry with matching tag and good parity, and no clear in progress |
| lk_taken_o | output | 1 | Prediction is taken |
| lk_target_o | output | PC_W | Stored target of the indexed entry |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_pc_i | input | PC_W | Address of the resolved branch |
| up_kind_i | input | 2 | 0 conditional, 1 unconditional, 2 return, 3 treated as unconditional |
| up_taken_i | input | 1 | Actual outcome |
| up_target_i | input | PC_W | Branch destination |
| up_pred_taken_i | input | 1 | Taken prediction that fetch used |
| up_pred_target_i | input | PC_W | Target that fetch used |
| clr_req_i | input | 1 | Invalidate all entries (barrier or synchronizing branch) |
| busy_o | output | 1 | Clear walk in progress |
| redirect_o | output | 1 | Mispredict recovery, two cycles |
| redirect_pc_o | output | PC_W | Corrected fetch address during recovery |

## Verification
The bench runs a 16-entry cache. It fills every index and then probes aliasing addresses. A tag slice that was too narrow would hit on those aliases. It drives one conditional branch through every 4-outcome pattern, checking the prediction and the redirect at each step. A counter that wrapped instead of saturating, or that started in the wrong state, would mispredict against the bench's arithmetic model. It trains a conditional entry to strongly not taken and then rewrites that entry as unconditional. A prediction that ignored the kind flag would then report not taken. It retargets a return, issues a clear in the cycle right after an update and sends an update during the walk. Stale entries that survived would show up as hits after the clear. Finally it forces the stored parity bit both ways, expecting a miss only for the wrong value.

// File: rtl/btc_pkg.sv
package btc_pkg;
    typedef enum logic [1:0] {
        BR_COND   = 2'd0,
        BR_UNCOND = 2'd1,
        BR_RETURN = 2'd2,
        BR_OTHER  = 2'd3
    } br_kind_e;

    localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;
    localparam logic [1:0] CTR_MAX        = 2'b11;
    localparam logic [1:0] CTR_MIN        = 2'b00;
endpackage

// File: rtl/btc_store.sv
module btc_store #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic [AW-1:0] ra0_i,
    output logic [W-1:0]  rd0_o,
    input  logic [AW-1:0] ra1_i,
    output logic [W-1:0]  rd1_o
);
    // inferred array: one write port, two asynchronous read ports
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[wa_i] <= wd_i;
    end

    assign rd0_o = mem_q[ra0_i];
    assign rd1_o = mem_q[ra1_i];
endmodule

// File: rtl/btc_predict.sv
module btc_predict #(
    parameter int TAG_W     = 24,
    parameter int PC_W      = 32,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic             ent_valid_i,
    input  logic [TAG_W-1:0] ent_tag_i,
    input  logic [PC_W-1:0]  ent_target_i,
    input  logic [1:0]       ent_ctr_i,
    input  logic             ent_unc_i,
    input  logic             ent_par_i,
    input  logic [TAG_W-1:0] look_tag_i,
    input  logic             blocked_i,
    output logic             hit_o,
    output logic             taken_o
);
    logic perr;

    generate
        if (PARITY_EN) begin : g_par
            assign perr = (^{ent_tag_i, ent_target_i, ent_ctr_i, ent_unc_i}) != ent_par_i;
        end else begin : g_nopar
            assign perr = 1'b0;
        end
    endgenerate

    always_comb begin
        hit_o   = ent_valid_i && (ent_tag_i == look_tag_i) && !perr && !blocked_i;
        taken_o = hit_o && (ent_unc_i || ent_ctr_i[1]);
    end
endmodule

// File: rtl/btc_update.sv
module btc_update
    import btc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            hit_i,
    input  logic [1:0]      old_ctr_i,
    input  logic [1:0]      kind_i,
    input  logic            taken_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            pred_taken_i,
    input  logic [PC_W-1:0] pred_target_i,
    output logic [1:0]      new_ctr_o,
    output logic            new_unc_o,
    output logic            mispredict_o,
    output logic [PC_W-1:0] fix_pc_o
);
    logic is_cond;

    always_comb begin
        is_cond   = br_kind_e'(kind_i) == BR_COND;
        new_unc_o = !is_cond;
        if (!hit_i) begin
            new_ctr_o = CTR_WEAK_TAKEN;
        end else if (!is_cond) begin
            new_ctr_o = old_ctr_i;
        end else if (taken_i) begin
            new_ctr_o = (old_ctr_i == CTR_MAX) ? CTR_MAX : old_ctr_i + 2'd1;
        end else begin
            new_ctr_o = (old_ctr_i == CTR_MIN) ? CTR_MIN : old_ctr_i - 2'd1;
        end
        mispredict_o = (taken_i != pred_taken_i) ||
                       (taken_i && pred_taken_i && (target_i != pred_target_i));
        fix_pc_o     = taken_i ? target_i : pc_i + PC_W'(4);
    end
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
    import btc_pkg::*;
#(
    parameter int ENTRIES   = 256,
    parameter int PC_W      = 32,
    parameter bit PARITY_EN = 1'b1,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int TAG_W    = PC_W - IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc_i,
    output logic            lk_hit_o,
    output logic            lk_taken_o,
    output logic [PC_W-1:0] lk_target_o,
    input  logic            up_valid_i,
    input  logic [PC_W-1:0] up_pc_i,
    input  logic [1:0]      up_kind_i,
    input  logic            up_taken_i,
    input  logic [PC_W-1:0] up_target_i,
    input  logic            up_pred_taken_i,
    input  logic [PC_W-1:0] up_pred_target_i,
    input  logic            clr_req_i,
    output logic            busy_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
        logic [1:0]       ctr;
        logic             unc;
        logic             par;
    } ent_t;
    localparam int ENT_W = $bits(ent_t);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cidx;
        logic [1:0]       rcnt;
        logic [PC_W-1:0]  rpc;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, up_idx, wa;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic [ENT_W-1:0] rd0, rd1, wd;
    ent_t             lk_ent, upd_old, new_ent;
    logic             lk_par, we;
    logic             upd_hit, upd_tk;
    logic [1:0]       new_ctr;
    logic             new_unc, mispredict;
    logic [PC_W-1:0]  fix_pc;

    // address split: index above the byte offset, tag is everything else
    assign lk_idx = lk_pc_i[IDX_W+1:2];
    assign up_idx = up_pc_i[IDX_W+1:2];
    assign lk_tag = {lk_pc_i[PC_W-1:IDX_W+2], lk_pc_i[1:0]};
    assign up_tag = {up_pc_i[PC_W-1:IDX_W+2], up_pc_i[1:0]};

    btc_store #(.DEPTH(ENTRIES), .W(ENT_W)) u_store (
        .clk   (clk),
        .we_i  (we),
        .wa_i  (wa),
        .wd_i  (wd),
        .ra0_i (lk_idx),
        .rd0_o (rd0),
        .ra1_i (up_idx),
        .rd1_o (rd1)
    );

    assign lk_ent  = rd0;
    assign upd_old = rd1;
    assign lk_par  = lk_ent.par;

    btc_predict #(.TAG_W(TAG_W), .PC_W(PC_W), .PARITY_EN(PARITY_EN)) u_look (
        .ent_valid_i  (lk_ent.valid),
        .ent_tag_i    (lk_ent.tag),
        .ent_target_i (lk_ent.target),
        .ent_ctr_i    (lk_ent.ctr),
        .ent_unc_i    (lk_ent.unc),
        .ent_par_i    (lk_par),
        .look_tag_i   (lk_tag),
        .blocked_i    (st_q.busy),
        .hit_o        (lk_hit_o),
        .taken_o      (lk_taken_o)
    );
    assign lk_target_o = lk_ent.target;

    btc_predict #(.TAG_W(TAG_W), .PC_W(PC_W), .PARITY_EN(PARITY_EN)) u_resolve (
        .ent_valid_i  (upd_old.valid),
        .ent_tag_i    (upd_old.tag),
        .ent_target_i (upd_old.target),
        .ent_ctr_i    (upd_old.ctr),
        .ent_unc_i    (upd_old.unc),
        .ent_par_i    (upd_old.par),
        .look_tag_i   (up_tag),
        .blocked_i    (1'b0),
        .hit_o        (upd_hit),
        .taken_o      (upd_tk)
    );

    btc_update #(.PC_W(PC_W)) u_update (
        .hit_i         (upd_hit),
        .old_ctr_i     (upd_old.ctr),
        .kind_i        (up_kind_i),
        .taken_i       (up_taken_i),
        .pc_i          (up_pc_i),
        .target_i      (up_target_i),
        .pred_taken_i  (up_pred_taken_i),
        .pred_target_i (up_pred_target_i),
        .new_ctr_o     (new_ctr),
        .new_unc_o     (new_unc),
        .mispredict_o  (mispredict),
        .fix_pc_o      (fix_pc)
    );

    always_comb begin
        new_ent        = '0;
        new_ent.valid  = 1'b1;
        new_ent.tag    = up_tag;
        new_ent.target = up_target_i;
        new_ent.ctr    = new_ctr;
        new_ent.unc    = new_unc;
        new_ent.par    = ^{up_tag, up_target_i, new_ctr, new_unc};

        // the clear walk owns the write port; updates during it are dropped
        we = st_q.busy || up_valid_i;
        wa = st_q.busy ? st_q.cidx : up_idx;
        wd = st_q.busy ? '0 : new_ent;

        st_d = st_q;
        if (st_q.busy) begin
            st_d.cidx = st_q.cidx + 1'b1;
            if (st_q.cidx == IDX_W'(ENTRIES - 1)) st_d.busy = 1'b0;
        end
        if (clr_req_i) begin
            st_d.busy = 1'b1;
            st_d.cidx = '0;
        end
        if (st_q.rcnt != 2'd0) st_d.rcnt = st_q.rcnt - 2'd1;
        if (up_valid_i && mispredict) begin
            st_d.rcnt = 2'd2;
            st_d.rpc  = fix_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.busy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o        = st_q.busy;
    assign redirect_o    = st_q.rcnt != 2'd0;
    assign redirect_pc_o = st_q.rpc;

    assert_walk_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(st_q.cidx) == IDX_W'(ENTRIES - 1));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_i && !busy_o && !clr_req_i) |=>
        (!$stable(up_pc_i) || (upd_hit && upd_old.target == $past(up_target_i))));

    assert_uncond_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_i && !busy_o && !clr_req_i && br_kind_e'(up_kind_i) != BR_COND) |=>
        (!$stable(up_pc_i) || upd_tk));

    assert_redirect_after_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_i && (up_taken_i != up_pred_taken_i)) |=>
        (redirect_o && redirect_pc_o == $past(up_taken_i ? up_target_i : up_pc_i + PC_W'(4))));

    assert_redirect_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_o) |=> redirect_o);

    assert_clear_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> busy_o);

    assert_no_hit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !lk_hit_o);
endmodule

// File: tb/test_branch_target_cache.sv
module test_branch_target_cache;
    localparam int N  = 16;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] lk_pc = '0;
    logic          lk_hit_o, lk_taken_o;
    logic [PW-1:0] lk_target_o;
    logic          up_valid = 1'b0;
    logic [PW-1:0] up_pc = '0;
    logic [1:0]    up_kind = 2'd0;
    logic          up_taken = 1'b0;
    logic [PW-1:0] up_target = '0;
    logic          up_pred_taken = 1'b0;
    logic [PW-1:0] up_pred_target = '0;
    logic          clr_req = 1'b0;
    logic          busy_o, redirect_o;
    logic [PW-1:0] redirect_pc_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit          mv  [N];
    logic [31:0] mpc [N];
    logic [31:0] mtg [N];
    logic [1:0]  mct [N];
    bit          mun [N];

    always #4 clk = ~clk;

    branch_target_cache #(.ENTRIES(N), .PC_W(PW), .PARITY_EN(1'b1)) i_branch_target_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_pc_i(lk_pc), .lk_hit_o(lk_hit_o), .lk_taken_o(lk_taken_o), .lk_target_o(lk_target_o),
        .up_valid_i(up_valid), .up_pc_i(up_pc), .up_kind_i(up_kind), .up_taken_i(up_taken),
        .up_target_i(up_target), .up_pred_taken_i(up_pred_taken), .up_pred_target_i(up_pred_target),
        .clr_req_i(clr_req), .busy_o(busy_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int ix(input logic [31:0] pc);
        return int'(pc[5:2]);
    endfunction

    function automatic bit mhit(input logic [31:0] pc);
        return mv[ix(pc)] && (mpc[ix(pc)][31:6] == pc[31:6]) && (mpc[ix(pc)][1:0] == pc[1:0]);
    endfunction

    function automatic bit mtaken(input logic [31:0] pc);
        return mhit(pc) && (mun[ix(pc)] || mct[ix(pc)] >= 2'd2);
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
    endtask

    task automatic m_upd(input logic [31:0] pc, input logic [1:0] kind, input bit tk,
                         input logic [31:0] tgt);
        int i;
        i = ix(pc);
        if (!mhit(pc)) mct[i] = 2'd2;
        else if (kind == 2'd0) begin
            if (tk && mct[i] != 2'd3) mct[i] = mct[i] + 2'd1;
            if (!tk && mct[i] != 2'd0) mct[i] = mct[i] - 2'd1;
        end
        mv[i] = 1'b1; mpc[i] = pc; mtg[i] = tgt; mun[i] = (kind != 2'd0);
    endtask

    task automatic look(input logic [31:0] pc);
        @(negedge clk);
        lk_pc = pc;
        #1;
    endtask

    task automatic expect_look(input string req, input logic [31:0] pc);
        look(pc);
        check(req, 32'(lk_hit_o), 32'(mhit(pc)));
        check(req, 32'(lk_taken_o), 32'(mtaken(pc)));
        if (mhit(pc)) check(req, lk_target_o, mtg[ix(pc)]);
    endtask

    task automatic upd(input string req, input logic [31:0] pc, input logic [1:0] kind,
                       input bit tk, input logic [31:0] tgt);
        bit etk, emp, r1, r2, r3;
        logic [31:0] etg, rp;
        expect_look(req, pc);
        etk = mtaken(pc);
        etg = mtg[ix(pc)];
        emp = (tk != etk) || (tk && etk && tgt != etg);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_kind = kind; up_taken = tk; up_target = tgt;
        up_pred_taken = lk_taken_o; up_pred_target = lk_target_o;
        m_upd(pc, kind, tk, tgt);
        @(posedge clk); #1; r1 = redirect_o; rp = redirect_pc_o;
        @(negedge clk); up_valid = 1'b0;
        @(posedge clk); #1; r2 = redirect_o;
        @(posedge clk); #1; r3 = redirect_o;
        check("R5 first cycle", 32'(r1), 32'(emp));
        check("R5 second cycle", 32'(r2), 32'(emp));
        check("R5 ends", 32'(r3), 32'd0);
        if (emp) check("R5 pc", rp, tk ? tgt : pc + 32'd4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] pc;
        bit p;
        m_clear();
        for (int i = 0; i < N; i++) begin mct[i] = 2'd0; mun[i] = 1'b0; mpc[i] = '0; mtg[i] = '0; end

        // R1: reset walk length and empty state
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 busy after reset", 32'(busy_o), 32'd1);
        check("R1 no redirect", 32'(redirect_o), 32'd0);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (busy_o && n < 1000);
        check("R1 walk length", n, N);
        for (int i = 0; i < N; i++) expect_look("R1 empty", 32'h0004_0000 + 32'(i * 4));

        // R2/R4/R5: allocate every index with a taken conditional
        for (int i = 0; i < N; i++)
            upd("R2 alloc", 32'h0004_0000 + 32'(i * 4), 2'd0, 1'b1, 32'h0008_0000 + 32'(i * 16));
        for (int i = 0; i < N; i++) begin
            expect_look("R4 weak taken", 32'h0004_0000 + 32'(i * 4));
            check("R4 taken", 32'(lk_taken_o), 32'd1);
        end
        // R10: same index, different upper bits or low bits
        for (int i = 0; i < N; i++) begin
            look(32'h0004_0040 + 32'(i * 4));
            check("R10 alias upper", 32'(lk_hit_o), 32'd0);
            look(32'h0014_0000 + 32'(i * 4));
            check("R10 alias high", 32'(lk_hit_o), 32'd0);
        end
        look(32'h0004_0001);
        check("R10 low bits", 32'(lk_hit_o), 32'd0);

        // R4/R5: every 4-outcome pattern on one conditional branch
        for (int pat = 0; pat < 16; pat++)
            for (int b = 0; b < 4; b++)
                upd("R4 counter", 32'h0004_000C, 2'd0, pat[b], 32'h0008_0030);

        // R3: drive entry to strongly not taken, then rewrite as unconditional
        for (int k = 0; k < 3; k++) upd("R4 down", 32'h0004_0014, 2'd0, 1'b0, 32'h0008_0050);
        check("R4 saturated low", 32'(mct[5]), 32'd0);
        upd("R3 uncond", 32'h0004_0014, 2'd1, 1'b1, 32'h0008_0050);
        expect_look("R3 uncond taken", 32'h0004_0014);
        check("R3 taken", 32'(lk_taken_o), 32'd1);

        // R6: return retargeting
        upd("R6 ret alloc", 32'h0004_0018, 2'd2, 1'b1, 32'h0000_1000);
        upd("R6 ret same", 32'h0004_0018, 2'd2, 1'b1, 32'h0000_1000);
        upd("R6 ret moved", 32'h0004_0018, 2'd2, 1'b1, 32'h0000_2200);
        expect_look("R6 new target", 32'h0004_0018);
        check("R6 target", lk_target_o, 32'h0000_2200);

        // R7: clear in the cycle right after an update; R8: update during walk
        @(negedge clk);
        up_valid = 1'b1; up_pc = 32'h0004_001C; up_kind = 2'd1; up_taken = 1'b1;
        up_target = 32'h0000_7770; up_pred_taken = 1'b0; up_pred_target = '0;
        @(negedge clk);
        up_valid = 1'b0; clr_req = 1'b1;
        @(posedge clk); #1;
        check("R7 busy", 32'(busy_o), 32'd1);
        @(negedge clk); clr_req = 1'b0;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (busy_o && n < 1000);
        check("R7 walk length", n, N);
        m_clear();
        for (int i = 0; i < N; i++) expect_look("R7 cleared", 32'h0004_0000 + 32'(i * 4));

        upd("R7 refill", 32'h0004_0000, 2'd0, 1'b1, 32'h0000_0100);
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        up_valid = 1'b1; up_pc = 32'h0004_0024; up_kind = 2'd1; up_taken = 1'b1;
        up_target = 32'h0000_0900; up_pred_taken = 1'b1; up_pred_target = 32'h0000_0900;
        #1;
        check("R7 miss while busy", 32'(lk_hit_o), 32'd0);
        @(negedge clk); up_valid = 1'b0;
        lk_pc = 32'h0004_0000; #1;
        check("R7 lookup busy", 32'(lk_hit_o), 32'd0);
        while (busy_o) @(negedge clk);
        m_clear();
        expect_look("R8 busy update dropped", 32'h0004_0024);
        expect_look("R7 refill gone", 32'h0004_0000);

        // R9: parity
        upd("R9 alloc", 32'h0004_0008, 2'd0, 1'b1, 32'h0000_0A5C);
        pc = 32'h0004_0008;
        p = ^{pc[31:6], pc[1:0], 32'h0000_0A5C, 2'b10, 1'b0};
        look(pc);
        check("R9 good parity hit", 32'(lk_hit_o), 32'd1);
        if (p) force i_branch_target_cache.lk_par = 1'b0;
        else   force i_branch_target_cache.lk_par = 1'b1;
        #1;
        check("R9 bad parity miss", 32'(lk_hit_o), 32'd0);
        check("R9 bad parity not taken", 32'(lk_taken_o), 32'd0);
        if (p) force i_branch_target_cache.lk_par = 1'b1;
        else   force i_branch_target_cache.lk_par = 1'b0;
        #1;
        check("R9 forced good hit", 32'(lk_hit_o), 32'd1);
        release i_branch_target_cache.lk_par;
        #1;
        check("R9 released hit", 32'(lk_hit_o), 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule